// File: doc/BRIEF.md
# Geometry Coprocessor Register File with Access Side Effects

This block is the 64-word by 32-bit register file of a geometry coprocessor. The host CPU reaches it through one synchronous write port and one combinational read port. Most addresses behave as plain storage. Some addresses change the value on the way in or out. Writes to 16-bit fields are sign- or zero-extended. One address pushes a three-deep screen-XY queue. A packed 5:5:5 colour word expands into three intermediate registers on write and is rebuilt from them on read. Writing the leading-bit source register updates a count register. A small set of addresses is read-only.

The coprocessor datapath feeds the file through three push streams: screen XY, screen Z and colour. Each stream uses a valid/ready handshake. The XY and Z streams clamp their inputs and record each clamp in the status word at address 63. A CPU write has priority over every stream. While `cpu_wr_en` is high, all three ready outputs are low and no push can complete. Streams may push in the same cycle as one another, because they touch disjoint registers and their status bits are combined by OR.

Top module: `gcop_regfile`

## Requirements
- R1: After reset every one of the 64 registers reads as zero.
- R2: A write to address 1, 3, 5, 8, 9, 10, 11, 36, 44, 52, 58, 59, 61 or 62 stores bits 15:0 of the data with bit 15 copied into bits 31:16. A write to any address not named in R2, R3, R5, R6, R8, R9 or R10 stores the 32-bit word unchanged.
- R3: A write to address 7, 16, 17, 18 or 19 stores bits 15:0 of the data with bits 31:16 cleared.
- R4: A write to address 15 moves entry 13 into 12 and entry 14 into 13, and places the data in 14. A read of address 15 returns entry 14.
- R5: A write to address 28 stores data bits 14:0, zero-extended. It also loads registers 9, 10 and 11 with data fields 4:0, 9:5 and 14:10 respectively, each multiplied by 128.
- R6: A read of address 28 or 29 returns a 15-bit word. Bits 4:0, 9:5 and 14:10 come from registers 9, 10 and 11 respectively. For each, the low 16 bits are read as a signed value. A negative value gives 0. Otherwise the value is divided by 128 and limited to 31.
- R7: A write to address 30 stores the data unchanged. It also sets register 31 to the number of leading bits, counted from bit 31, that equal bit 31. An all-zero or all-one word gives 32.
- R8: Writes to address 29 and to address 31 leave every register unchanged.
- R9: A write to address 63 keeps bits 30:12 of the data and clears bits 11:0. Bit 31 of register 63 always equals the OR of its bits 30:23 and 18:13.
- R10: An accepted Z push moves 17 into 16, 18 into 17 and 19 into 18. It loads 19 with the value clamped to 0..65535 and zero-extended. A clamp sets bit 18 of register 63.
- R11: An accepted XY push first clamps X and Y separately to -1024..1023. A clamped X sets bit 14 of register 63 and a clamped Y sets bit 13. The queue then shifts as in R4, and the new entry 14 holds X in bits 15:0 and Y in bits 31:16, each in 16-bit two's complement.
- R12: An accepted colour push moves 21 into 20 and 22 into 21, and loads 22 with the pushed word.
- R13: Every ready output is low while `cpu_wr_en` is high and high otherwise. A push that is not accepted has no effect. A CPU write in the same cycle takes effect alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_en | input | 1 | CPU write strobe |
| cpu_wr_addr | input | 6 | CPU write address |
| cpu_wr_data | input | 32 | CPU write data |
| cpu_rd_addr | input | 6 | CPU read address |
| cpu_rd_data | output | 32 | Combinational read data |
| xy_valid | input | 1 | Screen-XY push request |
| xy_ready | output | 1 | Screen-XY push accepted when high with valid |
| xy_x | input | PUSH_W | Signed X coordinate |
| xy_y | input | PUSH_W | Signed Y coordinate |
| z_valid | input | 1 | Screen-Z push request |
| z_ready | output | 1 | Screen-Z push accepted when high with valid |
| z_val | input | PUSH_W | Signed depth value |
| col_valid | input | 1 | Colour push request |
| col_ready | output | 1 | Colour push accepted when high with valid |
| col_data | input | 32 | Packed colour word |

## Verification
A write or accepted push takes effect at the rising edge where it is presented. Because the read port is combinational, the result is visible as soon as that edge has passed. Ready outputs depend only on `cpu_wr_en` in the same cycle. The bench drives every stimulus at a falling edge and removes it one time unit after the next rising edge. It then sweeps all 64 read addresses while the inputs are idle and compares each read against a bench model. Ready is sampled between drive and edge.

// File: rtl/gcop_pkg.sv
package gcop_pkg;
  localparam int REG_W  = 32;
  localparam int REG_N  = 64;
  localparam int ADDR_W = $clog2(REG_N);
  localparam int HALF_W = REG_W / 2;
  localparam int CH_W   = 5;
  localparam int CH_SH  = 7;
  localparam int LZ_W   = $clog2(REG_W + 1);

  localparam int A_IR1 = 9,  A_IR2 = 10, A_IR3 = 11;
  localparam int A_XY0 = 12, A_XY1 = 13, A_XY2 = 14;
  localparam int A_Z0  = 16, A_Z1  = 17, A_Z2  = 18, A_Z3 = 19;
  localparam int A_C0  = 20, A_C1  = 21, A_C2  = 22;
  localparam int A_CIN = 28, A_LZS = 30, A_LZR = 31, A_FLG = 63;

  localparam int F_SY = 13, F_SX = 14, F_SZ = 18, F_ERR = 31;

  typedef enum logic [2:0] {
    WK_PLAIN, WK_SEXT, WK_ZEXT, WK_XYPUSH, WK_COLOR, WK_LZC, WK_IGNORE, WK_FLAG
  } wkind_t;

  function automatic logic [REG_W-1:0] flag_fix(input logic [REG_W-1:0] f);
    logic [REG_W-1:0] r;
    r = {1'b0, f[30:12], 12'b0};
    r[F_ERR] = (|r[30:23]) | (|r[18:13]);
    return r;
  endfunction

  function automatic logic [CH_W-1:0] ch_pack(input logic [HALF_W-1:0] ir);
    logic [HALF_W-1:0] q;
    q = ir >> CH_SH;
    if (ir[HALF_W-1])           return '0;
    else if (q > 16'(2**CH_W-1)) return '1;
    else                        return q[CH_W-1:0];
  endfunction
endpackage

// File: rtl/gcop_wr_xform.sv
module gcop_wr_xform
  import gcop_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  data,
  output wkind_t            kind,
  output logic [REG_W-1:0]  xval
);
  always_comb begin
    unique case (addr)
      6'd1, 6'd3, 6'd5, 6'd8, 6'd9, 6'd10, 6'd11, 6'd36, 6'd44,
      6'd52, 6'd58, 6'd59, 6'd61, 6'd62: kind = WK_SEXT;
      6'd7, 6'd16, 6'd17, 6'd18, 6'd19:  kind = WK_ZEXT;
      6'd15:                             kind = WK_XYPUSH;
      6'd28:                             kind = WK_COLOR;
      6'd30:                             kind = WK_LZC;
      6'd29, 6'd31:                      kind = WK_IGNORE;
      6'd63:                             kind = WK_FLAG;
      default:                           kind = WK_PLAIN;
    endcase
  end

  always_comb begin
    unique case (kind)
      WK_SEXT:  xval = {{HALF_W{data[HALF_W-1]}}, data[HALF_W-1:0]};
      WK_ZEXT:  xval = {{HALF_W{1'b0}}, data[HALF_W-1:0]};
      WK_COLOR: xval = {{(REG_W-3*CH_W){1'b0}}, data[3*CH_W-1:0]};
      WK_FLAG:  xval = flag_fix(data);
      default:  xval = data;
    endcase
  end
endmodule

// File: rtl/gcop_lzc.sv
module gcop_lzc #(
  parameter int W  = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  din,
  output logic [CW-1:0] cnt
);
  logic [W-1:0] v;
  always_comb begin
    v   = din[W-1] ? ~din : din;
    cnt = CW'(W);
    for (int i = 0; i < W; i++)
      if (v[i]) cnt = CW'(W - 1 - i);
  end
endmodule

// File: rtl/gcop_clamp.sv
module gcop_clamp #(
  parameter int IN_W  = 32,
  parameter int OUT_W = 16,
  parameter int LO    = -1024,
  parameter int HI    = 1023
) (
  input  logic signed [IN_W-1:0] din,
  output logic [OUT_W-1:0]       dout,
  output logic                   sat
);
  logic signed [IN_W-1:0] c;
  always_comb begin
    sat = 1'b1;
    if (din < IN_W'(LO))      c = IN_W'(LO);
    else if (din > IN_W'(HI)) c = IN_W'(HI);
    else begin
      c   = din;
      sat = 1'b0;
    end
    dout = c[OUT_W-1:0];
  end
endmodule

// File: rtl/gcop_regfile.sv
module gcop_regfile
  import gcop_pkg::*;
#(
  parameter int PUSH_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr_en,
  input  logic [5:0]        cpu_wr_addr,
  input  logic [31:0]       cpu_wr_data,
  input  logic [5:0]        cpu_rd_addr,
  output logic [31:0]       cpu_rd_data,
  input  logic              xy_valid,
  output logic              xy_ready,
  input  logic [PUSH_W-1:0] xy_x,
  input  logic [PUSH_W-1:0] xy_y,
  input  logic              z_valid,
  output logic              z_ready,
  input  logic [PUSH_W-1:0] z_val,
  input  logic              col_valid,
  output logic              col_ready,
  input  logic [31:0]       col_data
);
  logic [REG_W-1:0] rf [REG_N];

  wkind_t           wkind;
  logic [REG_W-1:0] wxval;
  logic [LZ_W-1:0]  lz_cnt;
  logic [HALF_W-1:0] cx, cy, cz;
  logic             sx, sy, sz;
  logic             xy_fire, z_fire, col_fire;
  logic [REG_W-1:0] push_flags;

  gcop_wr_xform u_xf (.addr(cpu_wr_addr), .data(cpu_wr_data), .kind(wkind), .xval(wxval));
  gcop_lzc #(.W(REG_W)) u_lz (.din(cpu_wr_data), .cnt(lz_cnt));

  gcop_clamp #(.IN_W(PUSH_W), .OUT_W(HALF_W), .LO(-1024), .HI(1023))
    u_cx (.din(xy_x), .dout(cx), .sat(sx));
  gcop_clamp #(.IN_W(PUSH_W), .OUT_W(HALF_W), .LO(-1024), .HI(1023))
    u_cy (.din(xy_y), .dout(cy), .sat(sy));
  gcop_clamp #(.IN_W(PUSH_W), .OUT_W(HALF_W), .LO(0), .HI(65535))
    u_cz (.din(z_val), .dout(cz), .sat(sz));

  // CPU port owns the file in any cycle it writes.
  assign xy_ready  = ~cpu_wr_en;
  assign z_ready   = ~cpu_wr_en;
  assign col_ready = ~cpu_wr_en;
  assign xy_fire   = xy_valid  & xy_ready;
  assign z_fire    = z_valid   & z_ready;
  assign col_fire  = col_valid & col_ready;

  always_comb begin
    push_flags       = '0;
    push_flags[F_SX] = xy_fire & sx;
    push_flags[F_SY] = xy_fire & sy;
    push_flags[F_SZ] = z_fire  & sz;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < REG_N; i++) rf[i] <= '0;
    end else if (cpu_wr_en) begin
      unique case (wkind)
        WK_XYPUSH: begin
          rf[A_XY0] <= rf[A_XY1];
          rf[A_XY1] <= rf[A_XY2];
          rf[A_XY2] <= cpu_wr_data;
        end
        WK_COLOR: begin
          rf[A_CIN] <= wxval;
          rf[A_IR1] <= {{(REG_W-CH_W-CH_SH){1'b0}}, cpu_wr_data[CH_W-1:0],        {CH_SH{1'b0}}};
          rf[A_IR2] <= {{(REG_W-CH_W-CH_SH){1'b0}}, cpu_wr_data[2*CH_W-1:CH_W],   {CH_SH{1'b0}}};
          rf[A_IR3] <= {{(REG_W-CH_W-CH_SH){1'b0}}, cpu_wr_data[3*CH_W-1:2*CH_W], {CH_SH{1'b0}}};
        end
        WK_LZC: begin
          rf[A_LZS] <= cpu_wr_data;
          rf[A_LZR] <= REG_W'(lz_cnt);
        end
        WK_IGNORE: ;
        default: rf[cpu_wr_addr] <= wxval;
      endcase
    end else begin
      if (xy_fire) begin
        rf[A_XY0] <= rf[A_XY1];
        rf[A_XY1] <= rf[A_XY2];
        rf[A_XY2] <= {cy, cx};
      end
      if (z_fire) begin
        rf[A_Z0] <= rf[A_Z1];
        rf[A_Z1] <= rf[A_Z2];
        rf[A_Z2] <= rf[A_Z3];
        rf[A_Z3] <= {{HALF_W{1'b0}}, cz};
      end
      if (col_fire) begin
        rf[A_C0] <= rf[A_C1];
        rf[A_C1] <= rf[A_C2];
        rf[A_C2] <= col_data;
      end
      if (xy_fire | z_fire)
        rf[A_FLG] <= flag_fix(rf[A_FLG] | push_flags);
    end
  end

  always_comb begin
    unique case (cpu_rd_addr)
      6'd15:        cpu_rd_data = rf[A_XY2];
      6'd28, 6'd29: cpu_rd_data = {{(REG_W-3*CH_W){1'b0}},
                                   ch_pack(rf[A_IR3][HALF_W-1:0]),
                                   ch_pack(rf[A_IR2][HALF_W-1:0]),
                                   ch_pack(rf[A_IR1][HALF_W-1:0])};
      default:      cpu_rd_data = rf[cpu_rd_addr];
    endcase
  end

  // R4: CPU push into the XY queue shifts it by one place
  assert_xy_cpu_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr_en && cpu_wr_addr == 6'd15 |=>
      rf[A_XY2] == $past(cpu_wr_data) && rf[A_XY1] == $past(rf[A_XY2]));

  // R8: read-only count register holds across a direct write
  assert_lzr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr_en && cpu_wr_addr == 6'd31 |=> rf[A_LZR] == $past(rf[A_LZR]));

  // R7: count never exceeds the word width
  assert_lzr_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rf[A_LZR] <= REG_W);

  // R9: status word keeps low bits clear and its summary bit consistent
  assert_flag_shape_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rf[A_FLG][11:0] == 12'h0 &&
    rf[A_FLG][F_ERR] == ((|rf[A_FLG][30:23]) | (|rf[A_FLG][18:13])));

  // R10: Z push lands a value in 0..65535
  assert_z_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    z_valid && !cpu_wr_en |=> rf[A_Z3][31:16] == 16'h0);

  // R11: XY push lands both halves in -1024..1023
  assert_xy_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    xy_valid && !cpu_wr_en |=>
      $signed(rf[A_XY2][15:0]) >= -16'sd1024 && $signed(rf[A_XY2][15:0]) <= 16'sd1023 &&
      $signed(rf[A_XY2][31:16]) >= -16'sd1024 && $signed(rf[A_XY2][31:16]) <= 16'sd1023);

  // R13: a blocked colour push leaves the colour queue alone
  assert_col_blocked_R13: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && cpu_wr_en && (cpu_wr_addr < 6'd20 || cpu_wr_addr > 6'd22) |=>
      $stable(rf[A_C2]));
endmodule

// File: tb/gcop_regfile_test.sv
`timescale 1ns/1ps
module gcop_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr_en = 1'b0;
  logic [5:0]  cpu_wr_addr = '0;
  logic [31:0] cpu_wr_data = '0;
  logic [5:0]  cpu_rd_addr = '0;
  logic [31:0] cpu_rd_data;
  logic        xy_valid = 1'b0, z_valid = 1'b0, col_valid = 1'b0;
  logic        xy_ready, z_ready, col_ready;
  logic [31:0] xy_x = '0, xy_y = '0, z_val = '0, col_data = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [31:0] m [64];

  always #2.5 clk = ~clk;

  gcop_regfile uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_wr_en(cpu_wr_en), .cpu_wr_addr(cpu_wr_addr), .cpu_wr_data(cpu_wr_data),
    .cpu_rd_addr(cpu_rd_addr), .cpu_rd_data(cpu_rd_data),
    .xy_valid(xy_valid), .xy_ready(xy_ready), .xy_x(xy_x), .xy_y(xy_y),
    .z_valid(z_valid), .z_ready(z_ready), .z_val(z_val),
    .col_valid(col_valid), .col_ready(col_ready), .col_data(col_data));

  function automatic logic [31:0] mflag(input logic [31:0] v);
    logic [31:0] f;
    f = v & 32'h7FFF_F000;
    f[31] = (f[30:23] != 0) || (f[18:13] != 0);
    return f;
  endfunction

  function automatic int lead(input logic [31:0] d);
    int n = 0;
    for (int i = 31; i >= 0; i--) begin
      if (d[i] != d[31]) break;
      n++;
    end
    return n;
  endfunction

  function automatic logic [4:0] fld(input logic [31:0] r);
    int v;
    v = int'($signed(r[15:0]));
    if (v < 0) return 5'd0;
    return (v / 128 > 31) ? 5'd31 : 5'(v / 128);
  endfunction

  function automatic logic [31:0] mread(input int a);
    if (a == 15) return m[14];
    if (a == 28 || a == 29) return {17'b0, fld(m[11]), fld(m[10]), fld(m[9])};
    return m[a];
  endfunction

  function automatic string req_of(input int a);
    case (a)
      1, 3, 5, 8, 9, 10, 11, 36, 44, 52, 58, 59, 61, 62: return "R2";
      7, 16, 17, 18, 19: return "R3";
      15: return "R4";
      28: return "R5";
      30: return "R7";
      29, 31: return "R8";
      63: return "R9";
      default: return "R2";
    endcase
  endfunction

  function automatic void mwrite(input int a, input logic [31:0] d);
    case (a)
      1, 3, 5, 8, 9, 10, 11, 36, 44, 52, 58, 59, 61, 62: m[a] = {{16{d[15]}}, d[15:0]};
      7, 16, 17, 18, 19: m[a] = {16'h0, d[15:0]};
      15: begin m[12] = m[13]; m[13] = m[14]; m[14] = d; end
      28: begin
        m[28] = d & 32'h7FFF;
        m[9]  = 32'(d[4:0]) * 128;
        m[10] = 32'(d[9:5]) * 128;
        m[11] = 32'(d[14:10]) * 128;
      end
      30: begin m[30] = d; m[31] = 32'(lead(d)); end
      29, 31: ;
      63: m[63] = mflag(d);
      default: m[a] = d;
    endcase
  endfunction

  function automatic int clampi(input int v, input int lo, input int hi, inout bit s);
    s = 1'b1;
    if (v < lo) return lo;
    if (v > hi) return hi;
    s = 1'b0;
    return v;
  endfunction

  task automatic sweep(input string req);
    int bad = 0;
    for (int a = 0; a < 64; a++) begin
      cpu_rd_addr = 6'(a);
      #1;
      if (cpu_rd_data !== mread(a)) begin
        if (bad == 0)
          $display("FAIL %s addr %0d actual %h expected %h", req, a, cpu_rd_data, mread(a));
        bad++;
      end
    end
    n_chk++;
    if (bad != 0) n_fail++;
  endtask

  task automatic idle();
    cpu_wr_en = 1'b0; xy_valid = 1'b0; z_valid = 1'b0; col_valid = 1'b0;
  endtask

  task automatic do_write(input int a, input logic [31:0] d);
    @(negedge clk);
    cpu_wr_en = 1'b1; cpu_wr_addr = 6'(a); cpu_wr_data = d;
    @(posedge clk); #1; idle();
    mwrite(a, d);
    sweep(req_of(a));
  endtask

  task automatic do_xy(input int x, input int y);
    bit s1, s2; int cx, cy;
    @(negedge clk);
    xy_valid = 1'b1; xy_x = x; xy_y = y;
    @(posedge clk); #1; idle();
    cx = clampi(x, -1024, 1023, s1);
    cy = clampi(y, -1024, 1023, s2);
    m[12] = m[13]; m[13] = m[14];
    m[14] = {cy[15:0], cx[15:0]};
    m[63] = mflag(m[63] | (32'(s1) << 14) | (32'(s2) << 13));
    sweep("R11");
  endtask

  task automatic do_z(input int z);
    bit s; int c;
    @(negedge clk);
    z_valid = 1'b1; z_val = z;
    @(posedge clk); #1; idle();
    c = clampi(z, 0, 65535, s);
    m[16] = m[17]; m[17] = m[18]; m[18] = m[19];
    m[19] = 32'(c);
    m[63] = mflag(m[63] | (32'(s) << 18));
    sweep("R10");
  endtask

  task automatic do_col(input logic [31:0] d);
    @(negedge clk);
    col_valid = 1'b1; col_data = d;
    @(posedge clk); #1; idle();
    m[20] = m[21]; m[21] = m[22]; m[22] = d;
    sweep("R12");
  endtask

  // R13: all streams presented together with a CPU write
  task automatic do_clash(input int a, input logic [31:0] d);
    @(negedge clk);
    cpu_wr_en = 1'b1; cpu_wr_addr = 6'(a); cpu_wr_data = d;
    xy_valid = 1'b1; xy_x = 32'd3000; xy_y = 32'd7;
    z_valid = 1'b1; z_val = 32'd9;
    col_valid = 1'b1; col_data = 32'hCAFE_0001;
    #1;
    n_chk++;
    if (xy_ready !== 1'b0 || z_ready !== 1'b0 || col_ready !== 1'b0) begin
      n_fail++;
      $display("FAIL R13 ready actual %b%b%b expected 000", xy_ready, z_ready, col_ready);
    end
    @(posedge clk); #1; idle();
    #1;
    n_chk++;
    if (xy_ready !== 1'b1 || z_ready !== 1'b1 || col_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R13 ready actual %b%b%b expected 111", xy_ready, z_ready, col_ready);
    end
    mwrite(a, d);
    sweep("R13");
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h1234_5678);
    for (int i = 0; i < 64; i++) m[i] = '0;
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b1;
    sweep("R1");

    do_write(1, 32'hABCD_8001);       // R2 sign extension, negative
    do_write(62, 32'h1111_7FFF);      // R2 positive
    do_write(0, 32'hDEAD_BEEF);       // R2 plain storage
    do_write(16, 32'h1234_FFFF);      // R3
    do_write(7, 32'hFFFF_0042);       // R3
    do_write(15, 32'h0000_0011);      // R4
    do_write(15, 32'h0000_0022);
    do_write(15, 32'h0000_0033);
    do_write(28, 32'hFFFF_FFFF);      // R5, R6 all fields at 31
    do_write(9, 32'hFFFF_8000);       // R6 negative field gives 0
    do_write(10, 32'h0000_7FFF);      // R6 field limited to 31
    do_write(11, 32'h0000_0100);      // R6 field 2
    do_write(30, 32'h0000_0000);      // R7 zero gives 32
    do_write(30, 32'hFFFF_FFFF);      // R7 ones give 32
    do_write(30, 32'h0001_0000);      // R7 15
    do_write(30, 32'h8000_0000);      // R7 1
    do_write(31, 32'h0000_0005);      // R8
    do_write(29, 32'h0000_7FFF);      // R8
    do_write(63, 32'hFFFF_FFFF);      // R9
    do_write(63, 32'h0000_1000);      // R9 bit 12 outside summary
    do_write(63, 32'h0080_0000);      // R9 summary from bit 23
    do_write(63, 32'h0000_0000);
    do_z(-5);                         // R10 low clamp
    do_z(70000);                      // R10 high clamp
    do_z(300);
    do_xy(-2000, 5000);               // R11 both clamp
    do_xy(5, -7);
    do_col(32'h0102_0304);            // R12
    do_clash(40, 32'h5555_AAAA);      // R13

    for (int k = 0; k < 300; k++) begin
      int op;
      op = int'($urandom_range(0, 4));
      case (op)
        0: do_write(int'($urandom_range(0, 63)), $urandom());
        1: do_xy(int'($urandom_range(0, 4000)) - 2000, int'($urandom_range(0, 4000)) - 2000);
        2: do_z(int'($urandom_range(0, 80000)) - 5000);
        3: do_col($urandom());
        default: do_clash(int'($urandom_range(0, 63)), $urandom());
      endcase
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end
endmodule